// File: doc/BRIEF.md
# SOF frame-number capture register

This block keeps the 11-bit frame number taken from the most recent good USB start-of-frame token and presents it to a byte-wide CPU bus. The number is split into an upper byte, which carries the top frame bits, and a lower byte. Software reads the upper byte first. That read copies the lower eight frame bits into a shadow byte. The following lower-byte read returns the shadow byte, so the two bytes always come from the same frame, even if a new token arrives between the two accesses.

Each SOF token, good or corrupted, sets a sticky event flag. Software clears the flag by writing a one to it. A token whose CRC check failed never changes the stored number. While the SOF-mark option is off, such a token also produces a one-cycle error pulse on a separate output. The token decoder, the CRC checker and the wider interrupt logic sit outside this block.

Top module: `sof_frame_capture`

## Requirements
- R1: After reset the stored frame number, the shadow byte and the event flag are all zero, so every register read returns 0x00.
- R2: At the clock edge where `sof_strobe` and `sof_crc_ok` are both 1, the stored frame number takes the value of `sof_frame`.
- R3: A token with `sof_crc_ok` at 0 leaves the stored frame number unchanged, whatever the value of `mark_en`.
- R4: Every token, good or corrupted, sets the event flag at the same edge where a good token would load the number. A read at address 2 returns the flag in bit 0, with bits 7..1 at 0.
- R5: A write at address 2 with `wdata` bit 0 set clears the flag. A write with bit 0 clear leaves the flag as it is. A token in the same cycle as a clearing write leaves the flag set.
- R6: In the cycle after a corrupted token with `mark_en` at 0, `sof_err` is 1 for exactly one cycle. A corrupted token with `mark_en` at 1, and any good token, leave `sof_err` at 0.
- R7: A read at address 0 returns frame bits 10..8 in bits 2..0, with bits 7..3 at 0.
- R8: A read at address 0 copies frame bits 7..0 into the shadow byte. A read at address 1 returns the shadow byte. Nothing else changes the shadow byte, so a later token does not alter the value read at address 1.
- R9: When a good token and an address-0 read happen in the same cycle, the read data and the shadow byte both hold the number from before the token. The new upper bits are visible from the next cycle.
- R10: A read with `rd_en` at 0 gives 0x00, address 3 reads as 0x00, and reads at addresses 1 and 2 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof_strobe | input | 1 | One-cycle pulse for a decoded SOF token |
| sof_frame | input | 11 | Frame number field of the token |
| sof_crc_ok | input | 1 | Token passed its CRC check |
| mark_en | input | 1 | SOF-mark option enable |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 upper byte, 1 lower byte, 2 event flag |
| wdata | input | 8 | Write data, bit 0 used at address 2 |
| rdata | output | 8 | Read data |
| sof_event | output | 1 | Sticky SOF event flag |
| sof_err | output | 1 | One-cycle pulse for a corrupted token while mark is off |

## Verification
The bench builds the block with its default 11-bit frame width, 8-bit data width and combinational read path. With these values the upper byte has only three live bits, so the forced-zero bits 7..3 are exercised, and a full-range frame number such as 0x7FF reaches every stored bit. The bench's read-latency localparam is passed to the block's read-register option. Setting it to 1 builds the registered read variant, and the scoreboard then compares each result one cycle later.

// File: rtl/sof_cap_pkg.sv
package sof_cap_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_HI   = 2'd0,
      REG_LO   = 2'd1,
      REG_FLAG = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/sof_stamp_reg.sv
module sof_stamp_reg #(
   parameter int FRAME_W = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sof_strobe,
   input  logic [FRAME_W-1:0] sof_frame,
   input  logic               sof_crc_ok,
   input  logic               mark_en,
   input  logic               flag_clr,
   output logic [FRAME_W-1:0] stamp,
   output logic               event_flag,
   output logic               err_pulse
);
   logic good_sof;
   logic bad_sof;

   assign good_sof = sof_strobe && sof_crc_ok;
   assign bad_sof  = sof_strobe && !sof_crc_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stamp <= '0;
      end else if (good_sof) begin
         stamp <= sof_frame;
      end
   end

   // a new token wins over a software clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         event_flag <= 1'b0;
      end else if (sof_strobe) begin
         event_flag <= 1'b1;
      end else if (flag_clr) begin
         event_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_pulse <= 1'b0;
      end else begin
         err_pulse <= bad_sof && !mark_en;
      end
   end

   a_r2_load_good: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_strobe && sof_crc_ok) |=> (stamp == $past(sof_frame)));
   a_r3_hold_bad: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_strobe && !sof_crc_ok) |=> $stable(stamp));
   a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      sof_strobe |=> event_flag);
   a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !sof_strobe) |=> !event_flag);
   a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_strobe && !sof_crc_ok && !mark_en) |=> err_pulse);
   a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(sof_strobe && !sof_crc_ok && !mark_en) |=> !err_pulse);
endmodule

// File: rtl/sof_shadow_latch.sv
module sof_shadow_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] stamp_lo,
   output logic [DATA_W-1:0] shadow
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (load) begin
         shadow <= stamp_lo;
      end
   end

   a_r8_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (shadow == $past(stamp_lo)));
   a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(shadow));
endmodule

// File: rtl/sof_read_mux.sv
module sof_read_mux
   import sof_cap_pkg::*;
#(
   parameter int FRAME_W   = 11,
   parameter int DATA_W    = 8,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [FRAME_W-1:0] stamp,
   input  logic [DATA_W-1:0]  shadow,
   input  logic               event_flag,
   output logic [DATA_W-1:0]  rdata
);
   localparam int HI_W = FRAME_W - DATA_W;

   logic [DATA_W-1:0] mux_val;

   always_comb begin
      mux_val = '0;
      if (rd_en) begin
         unique case (addr)
            REG_HI:   mux_val = {{(DATA_W-HI_W){1'b0}}, stamp[FRAME_W-1:DATA_W]};
            REG_LO:   mux_val = shadow;
            REG_FLAG: mux_val = {{(DATA_W-1){1'b0}}, event_flag};
            default:  mux_val = '0;
         endcase
      end
   end

   generate
      if (RDATA_REG) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata <= '0;
            end else begin
               rdata <= mux_val;
            end
         end
      end else begin : g_comb_out
         assign rdata = mux_val;
      end
   endgenerate

   a_r7_hi_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == REG_HI) |-> (mux_val[DATA_W-1:HI_W] == '0));
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (mux_val == '0));
   a_r4_flag_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == REG_FLAG) |-> (mux_val[DATA_W-1:1] == '0));
endmodule

// File: rtl/sof_frame_capture.sv
module sof_frame_capture
   import sof_cap_pkg::*;
#(
   parameter int FRAME_W   = 11,
   parameter int DATA_W    = 8,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sof_strobe,
   input  logic [FRAME_W-1:0] sof_frame,
   input  logic               sof_crc_ok,
   input  logic               mark_en,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic               sof_event,
   output logic               sof_err
);
   localparam int HI_W = FRAME_W - DATA_W;

   generate
      if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_width
         $error("sof_frame_capture: FRAME_W must lie in DATA_W+1 .. 2*DATA_W");
      end
   endgenerate

   logic [FRAME_W-1:0] stamp;
   logic [DATA_W-1:0]  shadow;
   logic               event_flag;
   logic               hi_read;
   logic               flag_clr;

   assign hi_read  = rd_en && (addr == REG_HI);
   assign flag_clr = wr_en && (addr == REG_FLAG) && wdata[0];

   sof_stamp_reg #(.FRAME_W(FRAME_W)) u_stamp (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof_strobe (sof_strobe),
      .sof_frame  (sof_frame),
      .sof_crc_ok (sof_crc_ok),
      .mark_en    (mark_en),
      .flag_clr   (flag_clr),
      .stamp      (stamp),
      .event_flag (event_flag),
      .err_pulse  (sof_err)
   );

   sof_shadow_latch #(.DATA_W(DATA_W)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hi_read),
      .stamp_lo (stamp[DATA_W-1:0]),
      .shadow   (shadow)
   );

   sof_read_mux #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .RDATA_REG(RDATA_REG)) u_rmux (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en),
      .addr       (addr),
      .stamp      (stamp),
      .shadow     (shadow),
      .event_flag (event_flag),
      .rdata      (rdata)
   );

   assign sof_event = event_flag;

   a_r9_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_read && sof_strobe && sof_crc_ok) |=> (shadow == $past(stamp[DATA_W-1:0])));
   a_r10_lo_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == REG_LO && !sof_strobe) |=> ($stable(stamp) && $stable(shadow)));
endmodule

// File: tb/tb_sof_frame_capture.sv
module tb_sof_frame_capture;
   localparam int CLK_PERIOD = 10;
   localparam int FW = 11;
   localparam int DW = 8;
   localparam bit RD_LAT = 1'b0;

   typedef struct {
      logic [DW-1:0] exp_rdata;
      logic          exp_err;
      string         req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sof_strobe = 1'b0;
   logic [FW-1:0] sof_frame = '0;
   logic          sof_crc_ok = 1'b0;
   logic          mark_en = 1'b0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          sof_event;
   logic          sof_err;

   int n_checks = 0;
   int n_fail = 0;
   item_t q[$];

   // reference state
   logic [FW-1:0] m_stamp = '0;
   logic [DW-1:0] m_shadow = '0;
   logic          m_flag = 1'b0;
   logic          m_err = 1'b0;
   logic [DW-1:0] prev_exp = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sof_frame_capture #(.FRAME_W(FW), .DATA_W(DW), .RDATA_REG(RD_LAT)) dut (
      .clk(clk), .rst_n(rst_n), .sof_strobe(sof_strobe), .sof_frame(sof_frame),
      .sof_crc_ok(sof_crc_ok), .mark_en(mark_en), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .sof_event(sof_event), .sof_err(sof_err)
   );

   task automatic cyc(input logic s, input logic [FW-1:0] f, input logic ok,
                      input logic mk, input logic rd, input logic wr,
                      input logic [1:0] a, input logic [DW-1:0] wd, input string req);
      item_t it;
      logic [DW-1:0] e;
      @(posedge clk);
      #1;
      sof_strobe = s; sof_frame = f; sof_crc_ok = ok; mark_en = mk;
      rd_en = rd; wr_en = wr; addr = a; wdata = wd;
      e = '0;
      if (rd) begin
         case (a)
            2'd0: e = {5'b0, m_stamp[FW-1:DW]};
            2'd1: e = m_shadow;
            2'd2: e = {7'b0, m_flag};
            default: e = '0;
         endcase
      end
      it.exp_rdata = RD_LAT ? prev_exp : e;
      it.exp_err = m_err;
      it.req = req;
      prev_exp = e;
      q.push_back(it);
      if (rd && a == 2'd0) m_shadow = m_stamp[DW-1:0];
      if (s && ok) m_stamp = f;
      if (s) m_flag = 1'b1;
      else if (wr && a == 2'd2 && wd[0]) m_flag = 1'b0;
      m_err = s && !ok && !mk;
   endtask

   task automatic rd(input logic [1:0] a, input string req);
      cyc(1'b0, '0, 1'b0, mark_en, 1'b1, 1'b0, a, '0, req);
   endtask

   task automatic sof(input logic [FW-1:0] f, input logic ok, input logic mk, input string req);
      cyc(1'b1, f, ok, mk, 1'b0, 1'b0, 2'd0, '0, req);
   endtask

   task automatic idle(input string req);
      cyc(1'b0, '0, 1'b0, mark_en, 1'b0, 1'b0, 2'd0, '0, req);
   endtask

   // monitor: pops one expected item per driven cycle
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_checks += 2;
         if (rdata !== it.exp_rdata) begin
            n_fail++;
            $display("FAIL %s rdata actual=%02h expected=%02h", it.req, rdata, it.exp_rdata);
         end
         if (sof_err !== it.exp_err) begin
            n_fail++;
            $display("FAIL %s sof_err actual=%0b expected=%0b", it.req, sof_err, it.exp_err);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1"); rd(2'd3, "R10");
      n_checks++;
      if (sof_event !== 1'b0) begin
         n_fail++; $display("FAIL R1 sof_event actual=%0b expected=0", sof_event);
      end
      // R2 good token, R7 high read, R8 low via shadow, R4 flag
      sof(11'h5A3, 1'b1, 1'b0, "R2");
      rd(2'd0, "R7"); rd(2'd1, "R8"); rd(2'd2, "R4");
      // R5 clear with 1, write 0 keeps
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 8'h00, "R5");
      rd(2'd2, "R5");
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 8'hFF, "R5");
      rd(2'd2, "R5");
      // R3 / R6 corrupted, mark off
      sof(11'h111, 1'b0, 1'b0, "R3");
      idle("R6");
      rd(2'd0, "R3"); rd(2'd1, "R3"); rd(2'd2, "R4");
      // R3 / R6 corrupted, mark on: no error pulse
      sof(11'h0EE, 1'b0, 1'b1, "R6");
      idle("R6");
      rd(2'd0, "R3"); rd(2'd1, "R3");
      // R8 token between high and low read does not tear
      rd(2'd0, "R8");
      sof(11'h7FF, 1'b1, 1'b0, "R2");
      rd(2'd1, "R8");
      rd(2'd0, "R7"); rd(2'd1, "R8");
      // R9 token and high read in one cycle
      cyc(1'b1, 11'h234, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, '0, "R9");
      rd(2'd1, "R9");
      rd(2'd0, "R9"); rd(2'd1, "R9");
      // R5 token wins over clear
      cyc(1'b1, 11'h001, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 8'h01, "R5");
      rd(2'd2, "R5");
      // R10 low and flag reads do not change state, rd_en low gives zero
      rd(2'd1, "R10"); rd(2'd2, "R10"); rd(2'd1, "R10");
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R10");
      rd(2'd3, "R10");
      rd(2'd0, "R7"); rd(2'd1, "R8");
      idle("R10"); idle("R10");
      @(posedge clk);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule